// File: doc/BRIEF.md
# Buffered I2C Chunk Sequencer

This block runs a single chunk of an I2C controller transaction out of a local byte buffer. The host first loads the buffer through a valid/ready input stream. It then raises `run` for one cycle together with a configuration: a write count, a read count, START and STOP requests, an automatic turnaround into the read phase, a firmware-ACK option and an SMBus-style block-read option. The sequencer issues a START if one was requested. It sends the buffered bytes, which hold the target address first on the opening chunk, and can then receive bytes into the buffer directly after the written ones. It ends with a STOP only when one was asked for. Received bytes come back through a valid/ready output stream.

The I2C bus is reduced to a byte-level operation handshake. The block presents one operation (START, WRITE, READ or STOP) with `bus_valid` and holds it until the bus side answers with `bus_ready`. In the same cycle the bus side returns the target's NAK for a WRITE, or the received byte for a READ. Bit timing belongs to the bus side. Transactions longer than the buffer are split into chunks. The firmware-ACK option keeps the final byte of an intermediate read chunk ACKed, and leaving STOP off keeps the bus owned between chunks.

When a chunk ends, the block raises sticky status flags and a termination flag, which drives `irq` unless it is masked. Software clears each flag by writing 1 to it.

Top module: `i2c_chunk_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `bus_valid`=0, `flags`=0, `irq`=0 and `in_ready`=1.
- R2: While idle, each `in_valid`&`in_ready` stores `in_data` at the next buffer index, starting from 0. Each `out_valid`&`out_ready` steps through the buffer in index order, with `out_data` showing the current byte. While `busy` is high, `in_ready` and `out_valid` are both 0.
- R3: A one-cycle `ctr_reset` pulse returns both host stream indices to 0.
- R4: A `run` pulse while idle latches the configuration. If `cfg_start`=1, the first operation is START (`bus_op`=0). Then `cfg_wr_cnt` WRITE operations (`bus_op`=1) carry buffer bytes 0, 1, 2 and so on in `bus_wdata`.
- R5: A read phase of `cfg_rd_cnt` READ operations (`bus_op`=2) follows the writes only when `cfg_rd_cnt`>0 and either `cfg_auto_rd`=1 or `cfg_wr_cnt`=0. Received bytes are stored in the buffer directly after the written bytes.
- R6: Every READ carries `bus_ack`=1, except the last READ of a chunk run with `cfg_fw_ack`=0, which carries `bus_ack`=0. No READ follows a READ with `bus_ack`=0 in the same chunk.
- R7: A STOP operation (`bus_op`=3) ends the chunk only when `cfg_stop`=1, and only then is the idle flag set.
- R8: A WRITE answered with `bus_nak`=1 sets the NAK flag. It skips every remaining write and read of the chunk, and the chunk still issues STOP if one was requested.
- R9: With `cfg_block_rd`=1, the first received byte is ACKed and gives the number N of further bytes to read, limited to the room left in the buffer. If N=0, the read phase ends after that first byte.
- R10: `flags` bit 0 is done, bit 1 is bus idle, bit 2 is NAK and bit 3 is termination. Each bit is sticky and clears when 1 is written to the same bit of `flag_clr`. A set in the same cycle wins over the clear.
- R11: Done and termination are set when every chunk ends. `irq` is high while the termination flag is 1 and `irq_mask`=0.
- R12: A `run` pulse while a chunk is in progress has no effect.
- R13: While `bus_valid`=1 and `bus_ready`=0, the operation and its fields stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start a chunk (one-cycle pulse) |
| cfg_start | input | 1 | Issue START before the chunk |
| cfg_stop | input | 1 | Issue STOP after the chunk |
| cfg_auto_rd | input | 1 | Turn into the read phase after the writes |
| cfg_fw_ack | input | 1 | ACK the final read byte of the chunk |
| cfg_block_rd | input | 1 | Take the read length from the first received byte |
| cfg_wr_cnt | input | CW | Bytes to write, address included |
| cfg_rd_cnt | input | CW | Bytes to read |
| ctr_reset | input | 1 | Return the host stream indices to zero |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Buffer accepts a host byte |
| in_data | input | 8 | Host byte |
| out_valid | output | 1 | Buffer byte available |
| out_ready | input | 1 | Host takes the buffer byte |
| out_data | output | 8 | Buffer byte |
| bus_valid | output | 1 | Bus operation requested |
| bus_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| bus_wdata | output | 8 | Byte to send on WRITE |
| bus_ack | output | 1 | ACK (1) or NACK (0) to return on READ |
| bus_ready | input | 1 | Bus completes the operation |
| bus_rdata | input | 8 | Byte received on READ |
| bus_nak | input | 1 | Target NAKed the WRITE |
| busy | output | 1 | Chunk in progress |
| flags | output | 4 | Sticky completion flags |
| flag_clr | input | 4 | Write-1-to-clear for flags |
| irq_mask | input | 1 | 1 suppresses irq |
| irq | output | 1 | Termination interrupt |

## Verification
The hardest situation to reach is a second `run` that lands in the middle of a chunk. With an always-ready bus a short chunk ends too quickly to aim at. The scoreboard's bus model therefore withholds `bus_ready` on every other cycle, which stretches a three-byte write chunk. The bench fires a conflicting `run` (no START, no counts) while `busy` is seen high. An accepted pulse would restart or shorten the operation stream, and that shows up as a scoreboard mismatch or a missing STOP. The same stalls also exercise the hold rule on the bus handshake. Block-read turnaround and the NAK abort are reached by having the bus model answer with a count byte or a NAK that the bench has scripted.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {
    BUS_START = 2'd0,
    BUS_WRITE = 2'd1,
    BUS_READ  = 2'd2,
    BUS_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_WR, ST_RD, ST_STOP, ST_END
  } seq_st_e;

  localparam int FLAG_DONE = 0;
  localparam int FLAG_IDLE = 1;
  localparam int FLAG_NAK  = 2;
  localparam int FLAG_TERM = 3;
  localparam int NFLAGS    = 4;
endpackage

// File: rtl/i2c_seq_buf.sv
module i2c_seq_buf #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          ctr_reset,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  input  logic [PW-1:0] seq_ptr,
  input  logic          seq_we,
  input  logic [7:0]    seq_wdata,
  output logic [7:0]    seq_rdata
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;

  assign in_ready  = !busy && (wp < PW'(DEPTH));
  assign out_valid = !busy && (rp < PW'(DEPTH));
  assign out_data  = mem[rp[AW-1:0]];
  assign seq_rdata = mem[seq_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (seq_we)
      mem[seq_ptr[AW-1:0]] <= seq_wdata;
    else if (in_valid && in_ready)
      mem[wp[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctr_reset) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (in_valid && in_ready)   wp <= wp + 1'b1;
      if (out_valid && out_ready) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_seq_flags.sv
module i2c_seq_flags
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_p,
  input  logic              idle_p,
  input  logic              nak_p,
  input  logic [NFLAGS-1:0] flag_clr,
  input  logic              irq_mask,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);
  logic [NFLAGS-1:0] set_v;

  always_comb begin
    set_v            = '0;
    set_v[FLAG_DONE] = done_p;
    set_v[FLAG_IDLE] = idle_p;
    set_v[FLAG_NAK]  = nak_p;
    set_v[FLAG_TERM] = done_p;
  end

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= set_v[i] | (flags[i] & ~flag_clr[i]);
    end
  end

  assign irq = flags[FLAG_TERM] & ~irq_mask;
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cfg_start,
  input  logic          cfg_stop,
  input  logic          cfg_auto_rd,
  input  logic          cfg_fw_ack,
  input  logic          cfg_block_rd,
  input  logic [CW-1:0] cfg_wr_cnt,
  input  logic [CW-1:0] cfg_rd_cnt,
  output logic          bus_valid,
  output logic [1:0]    bus_op,
  output logic [7:0]    bus_wdata,
  output logic          bus_ack,
  input  logic          bus_ready,
  input  logic [7:0]    bus_rdata,
  input  logic          bus_nak,
  output logic [PW-1:0] seq_ptr,
  output logic          seq_we,
  input  logic [7:0]    seq_rdata,
  output logic          busy,
  output logic          done_p,
  output logic          idle_p,
  output logic          nak_p
);
  seq_st_e       st;
  logic [CW-1:0] wleft, rleft;
  logic          stop_l, fwack_l, blk_l, blk_first, rdgo;
  logic [CW-1:0] wr_eff, rd_eff, blk_n;
  logic          go_rd, fire, last_rd;
  seq_st_e       fin_st;

  always_comb begin
    int unsigned room, dv;
    wr_eff = (cfg_wr_cnt > CW'(DEPTH)) ? CW'(DEPTH) : cfg_wr_cnt;
    rd_eff = (cfg_rd_cnt > CW'(DEPTH) - wr_eff) ? CW'(DEPTH) - wr_eff : cfg_rd_cnt;
    go_rd  = (rd_eff != '0) && (cfg_auto_rd || wr_eff == '0);
    room   = DEPTH - 1 - 32'(seq_ptr);
    dv     = 32'(bus_rdata);
    blk_n  = CW'((dv < room) ? dv : room);
    fin_st = stop_l ? ST_STOP : ST_END;
  end

  always_comb begin
    bus_valid = (st == ST_START) || (st == ST_WR) || (st == ST_RD) || (st == ST_STOP);
    case (st)
      ST_START: bus_op = BUS_START;
      ST_WR:    bus_op = BUS_WRITE;
      ST_RD:    bus_op = BUS_READ;
      default:  bus_op = BUS_STOP;
    endcase
    bus_wdata = seq_rdata;
    last_rd   = (rleft == CW'(1)) && !(blk_l && blk_first);
    bus_ack   = !(last_rd && !fwack_l);
    fire      = bus_valid && bus_ready;
    seq_we    = (st == ST_RD) && fire;
    nak_p     = (st == ST_WR) && fire && bus_nak;
    done_p    = (st == ST_END);
    idle_p    = (st == ST_END) && stop_l;
    busy      = (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      seq_ptr <= '0;
      wleft <= '0;
      rleft <= '0;
      stop_l <= 1'b0;
      fwack_l <= 1'b0;
      blk_l <= 1'b0;
      blk_first <= 1'b0;
      rdgo <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (run) begin
          stop_l    <= cfg_stop;
          fwack_l   <= cfg_fw_ack;
          blk_l     <= cfg_block_rd;
          blk_first <= 1'b1;
          seq_ptr   <= '0;
          wleft     <= wr_eff;
          rleft     <= rd_eff;
          rdgo      <= go_rd;
          if (cfg_start)            st <= ST_START;
          else if (wr_eff != '0)    st <= ST_WR;
          else if (go_rd)           st <= ST_RD;
          else                      st <= cfg_stop ? ST_STOP : ST_END;
        end
        ST_START: if (fire) begin
          if (wleft != '0) st <= ST_WR;
          else if (rdgo)   st <= ST_RD;
          else             st <= fin_st;
        end
        ST_WR: if (fire) begin
          seq_ptr <= seq_ptr + 1'b1;
          wleft   <= wleft - 1'b1;
          if (bus_nak)                  st <= fin_st;
          else if (wleft == CW'(1))     st <= rdgo ? ST_RD : fin_st;
        end
        ST_RD: if (fire) begin
          seq_ptr <= seq_ptr + 1'b1;
          if (blk_l && blk_first) begin
            blk_first <= 1'b0;
            rleft     <= blk_n;
            if (blk_n == '0) st <= fin_st;
          end else begin
            rleft <= rleft - 1'b1;
            if (rleft == CW'(1)) st <= fin_st;
          end
        end
        ST_STOP: if (fire) st <= ST_END;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_chunk_seq.sv
module i2c_chunk_seq
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cfg_start,
  input  logic          cfg_stop,
  input  logic          cfg_auto_rd,
  input  logic          cfg_fw_ack,
  input  logic          cfg_block_rd,
  input  logic [CW-1:0] cfg_wr_cnt,
  input  logic [CW-1:0] cfg_rd_cnt,
  input  logic          ctr_reset,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          bus_valid,
  output logic [1:0]    bus_op,
  output logic [7:0]    bus_wdata,
  output logic          bus_ack,
  input  logic          bus_ready,
  input  logic [7:0]    bus_rdata,
  input  logic          bus_nak,
  output logic          busy,
  output logic [3:0]    flags,
  input  logic [3:0]    flag_clr,
  input  logic          irq_mask,
  output logic          irq
);
  logic [PW-1:0] seq_ptr;
  logic          seq_we;
  logic [7:0]    seq_rdata;
  logic          done_p, idle_p, nak_p;

  i2c_seq_buf #(.DEPTH(DEPTH)) u_buf (
    .clk, .rst_n, .busy, .ctr_reset,
    .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data,
    .seq_ptr, .seq_we, .seq_wdata(bus_rdata), .seq_rdata
  );

  i2c_seq_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk, .rst_n, .run,
    .cfg_start, .cfg_stop, .cfg_auto_rd, .cfg_fw_ack, .cfg_block_rd,
    .cfg_wr_cnt, .cfg_rd_cnt,
    .bus_valid, .bus_op, .bus_wdata, .bus_ack,
    .bus_ready, .bus_rdata, .bus_nak,
    .seq_ptr, .seq_we, .seq_rdata,
    .busy, .done_p, .idle_p, .nak_p
  );

  i2c_seq_flags u_flags (
    .clk, .rst_n, .done_p, .idle_p, .nak_p,
    .flag_clr, .irq_mask, .flags, .irq
  );
endmodule

// File: rtl/i2c_chunk_seq_chk.sv
module i2c_chunk_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       bus_valid,
  input logic       bus_ready,
  input logic [1:0] bus_op,
  input logic [7:0] bus_wdata,
  input logic       bus_ack,
  input logic       bus_nak,
  input logic [3:0] flags,
  input logic       in_ready,
  input logic       out_valid
);
  a_r1_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid);

  a_r2_streams_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!in_ready && !out_valid));

  a_r6_nack_ends_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_op == 2'd2 && !bus_ack) |=> !(bus_valid && bus_op == 2'd2));

  a_r8_nak_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_op == 2'd1 && bus_nak) |=> flags[2]);

  a_r11_term_at_chunk_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> $past(busy));

  a_r13_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_op) && $stable(bus_wdata) && $stable(bus_ack)));
endmodule

bind i2c_chunk_seq i2c_chunk_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_op(bus_op),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_nak(bus_nak),
  .flags(flags), .in_ready(in_ready), .out_valid(out_valid)
);

// File: tb/i2c_chunk_seq_bench.sv
`timescale 1ns/1ps
module i2c_chunk_seq_bench;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, cfg_start = 0, cfg_stop = 0, cfg_auto_rd = 0, cfg_fw_ack = 0, cfg_block_rd = 0;
  logic [CW-1:0] cfg_wr_cnt = '0, cfg_rd_cnt = '0;
  logic ctr_reset = 0, in_valid = 0, out_ready = 0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, bus_valid, bus_ack, busy, irq;
  logic [7:0] out_data, bus_wdata;
  logic [1:0] bus_op;
  logic bus_ready = 0, bus_nak = 0;
  logic [7:0] bus_rdata = '0;
  logic [3:0] flags;
  logic [3:0] flag_clr = '0;
  logic irq_mask = 0;

  int ntest = 0, nfail = 0;
  bit finished = 0;
  bit stall_en = 0, stall_tog = 0;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] d;
    logic       ack;
    logic [7:0] rd;
    logic       nak;
  } exp_t;
  exp_t  expq[$];
  string tagq[$];

  always #2.5 clk = ~clk;

  i2c_chunk_seq u_i2c_chunk_seq (
    .clk, .rst_n, .run, .cfg_start, .cfg_stop, .cfg_auto_rd, .cfg_fw_ack,
    .cfg_block_rd, .cfg_wr_cnt, .cfg_rd_cnt, .ctr_reset,
    .in_valid, .in_ready, .in_data, .out_valid, .out_ready, .out_data,
    .bus_valid, .bus_op, .bus_wdata, .bus_ack, .bus_ready, .bus_rdata, .bus_nak,
    .busy, .flags, .flag_clr, .irq_mask, .irq
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic exp_op(input logic [1:0] op, input logic [7:0] d, input logic ack,
                        input logic [7:0] rd, input logic nak, input string tag);
    exp_t e;
    e.op = op; e.d = d; e.ack = ack; e.rd = rd; e.nak = nak;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  // Bus model and scoreboard monitor: pops expected operations as they are served.
  always @(negedge clk) begin
    if (bus_valid && !(stall_en && stall_tog)) begin
      if (expq.size() == 0) begin
        check(1'b0, "R12 unexpected bus operation", int'(bus_op), -1);
        bus_nak = 0; bus_rdata = '0;
      end else begin
        exp_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(bus_op == e.op, {t, " op"}, int'(bus_op), int'(e.op));
        if (e.op == 2'd1) check(bus_wdata == e.d, {t, " wdata"}, int'(bus_wdata), int'(e.d));
        if (e.op == 2'd2) check(bus_ack == e.ack, {t, " ack"}, int'(bus_ack), int'(e.ack));
        bus_nak = e.nak; bus_rdata = e.rd;
      end
      bus_ready = 1;
    end else begin
      bus_ready = 0;
    end
    if (bus_valid) stall_tog = !stall_tog;
  end

  task automatic push_byte(input logic [7:0] b);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pop_check(input logic [7:0] expv, input string tag);
    check(out_valid == 1'b1, {tag, " out_valid"}, int'(out_valid), 1);
    check(out_data == expv, {tag, " out_data"}, int'(out_data), int'(expv));
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic counters_reset();
    ctr_reset = 1;
    @(negedge clk);
    ctr_reset = 0;
  endtask

  task automatic clear_flags(input logic [3:0] m);
    flag_clr = m;
    @(negedge clk);
    flag_clr = '0;
  endtask

  task automatic start_chunk(input bit st, input bit sp, input bit ar, input bit fw, input bit bk,
                             input int wr, input int rd);
    cfg_start = st; cfg_stop = sp; cfg_auto_rd = ar; cfg_fw_ack = fw; cfg_block_rd = bk;
    cfg_wr_cnt = CW'(wr); cfg_rd_cnt = CW'(rd);
    run = 1;
    @(negedge clk);
    run = 0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  task automatic end_chunk(input logic [3:0] fexp, input string tag);
    wait_done();
    check(expq.size() == 0, {tag, " all ops seen"}, expq.size(), 0);
    check(flags == fexp, {tag, " flags"}, int'(flags), int'(fexp));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", int'(busy), 0);
    check(bus_valid == 0, "R1 bus_valid", int'(bus_valid), 0);
    check(flags == 4'h0, "R1 flags", int'(flags), 0);
    check(irq == 0, "R1 irq", int'(irq), 0);
    check(in_ready == 1, "R1 in_ready", int'(in_ready), 1);

    // R4 write chunk with START and STOP
    push_byte(8'hA0); push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    exp_op(2'd0, 0, 0, 0, 0, "R4 start");
    exp_op(2'd1, 8'hA0, 0, 0, 0, "R4 addr");
    exp_op(2'd1, 8'h11, 0, 0, 0, "R4 byte1");
    exp_op(2'd1, 8'h22, 0, 0, 0, "R4 byte2");
    exp_op(2'd1, 8'h33, 0, 0, 0, "R7 byte3");
    exp_op(2'd3, 0, 0, 0, 0, "R7 stop");
    start_chunk(1, 1, 0, 0, 0, 4, 0);
    end_chunk(4'b1011, "R11 write chunk");
    check(irq == 1, "R11 irq raised", int'(irq), 1);
    clear_flags(4'b0001);
    check(flags == 4'b1010, "R10 partial clear", int'(flags), 4'b1010);
    clear_flags(4'hF);
    check(flags == 4'h0 && irq == 0, "R10 full clear", int'(flags), 0);

    // R5/R6 read with auto turnaround, final byte NACKed
    counters_reset();
    push_byte(8'hA1);
    exp_op(2'd0, 0, 0, 0, 0, "R4 start");
    exp_op(2'd1, 8'hA1, 0, 0, 0, "R5 addr");
    exp_op(2'd2, 0, 1, 8'h5A, 0, "R6 rd0 ack");
    exp_op(2'd2, 0, 1, 8'h6B, 0, "R6 rd1 ack");
    exp_op(2'd2, 0, 0, 8'h7C, 0, "R6 rd2 nack");
    exp_op(2'd3, 0, 0, 0, 0, "R7 stop");
    start_chunk(1, 1, 1, 0, 0, 1, 3);
    end_chunk(4'b1011, "R5 read chunk");
    counters_reset();
    pop_check(8'hA1, "R3 idx0");
    pop_check(8'h5A, "R5 idx1");
    pop_check(8'h6B, "R5 idx2");
    pop_check(8'h7C, "R5 idx3");
    clear_flags(4'hF);

    // R6/R7/R11 continuation chunk: firmware ACK, no STOP, irq masked
    irq_mask = 1;
    exp_op(2'd2, 0, 1, 8'h91, 0, "R6 cont rd0");
    exp_op(2'd2, 0, 1, 8'h92, 0, "R6 cont last acked");
    start_chunk(0, 0, 0, 1, 0, 0, 2);
    end_chunk(4'b1001, "R7 no stop no idle");
    check(irq == 0, "R11 irq masked", int'(irq), 0);
    counters_reset();
    pop_check(8'h91, "R5 cont idx0");
    pop_check(8'h92, "R5 cont idx1");
    irq_mask = 0;
    @(negedge clk);
    check(irq == 1, "R11 irq unmasked", int'(irq), 1);
    clear_flags(4'hF);

    // R8 NAK on address aborts the chunk
    counters_reset();
    push_byte(8'hA0); push_byte(8'h01); push_byte(8'h02);
    exp_op(2'd0, 0, 0, 0, 0, "R4 start");
    exp_op(2'd1, 8'hA0, 0, 0, 1, "R8 addr nak");
    exp_op(2'd3, 0, 0, 0, 0, "R8 stop after nak");
    start_chunk(1, 1, 0, 0, 0, 3, 0);
    end_chunk(4'b1111, "R8 nak chunk");
    clear_flags(4'hF);

    // R9 block read: first byte gives the remaining count
    counters_reset();
    push_byte(8'hA3);
    exp_op(2'd0, 0, 0, 0, 0, "R4 start");
    exp_op(2'd1, 8'hA3, 0, 0, 0, "R9 addr");
    exp_op(2'd2, 0, 1, 8'h02, 0, "R9 count byte");
    exp_op(2'd2, 0, 1, 8'h44, 0, "R9 data0");
    exp_op(2'd2, 0, 0, 8'h55, 0, "R9 data1 nack");
    exp_op(2'd3, 0, 0, 0, 0, "R9 stop");
    start_chunk(1, 1, 1, 0, 1, 1, 1);
    end_chunk(4'b1011, "R9 block chunk");
    counters_reset();
    pop_check(8'hA3, "R9 idx0");
    pop_check(8'h02, "R9 idx1");
    pop_check(8'h44, "R9 idx2");
    pop_check(8'h55, "R9 idx3");
    clear_flags(4'hF);

    // R12/R13 run during a stalled chunk is ignored
    counters_reset();
    push_byte(8'hA0); push_byte(8'hC1); push_byte(8'hC2);
    stall_en = 1;
    exp_op(2'd0, 0, 0, 0, 0, "R13 start");
    exp_op(2'd1, 8'hA0, 0, 0, 0, "R13 addr");
    exp_op(2'd1, 8'hC1, 0, 0, 0, "R12 byte1");
    exp_op(2'd1, 8'hC2, 0, 0, 0, "R12 byte2");
    exp_op(2'd3, 0, 0, 0, 0, "R12 stop");
    start_chunk(1, 1, 0, 0, 0, 3, 0);
    @(negedge clk);
    check(busy == 1, "R12 busy mid chunk", int'(busy), 1);
    check(in_ready == 0 && out_valid == 0, "R2 streams blocked", int'({in_ready, out_valid}), 0);
    start_chunk(0, 0, 0, 0, 0, 0, 0);
    end_chunk(4'b1011, "R12 ignored run");
    repeat (4) @(negedge clk);
    check(bus_valid == 0, "R12 no extra ops", int'(bus_valid), 0);
    stall_en = 0;
    clear_flags(4'hF);

    // R5 read skipped without auto turnaround
    counters_reset();
    push_byte(8'hA1);
    exp_op(2'd0, 0, 0, 0, 0, "R4 start");
    exp_op(2'd1, 8'hA1, 0, 0, 0, "R5 addr only");
    exp_op(2'd3, 0, 0, 0, 0, "R5 no read stop");
    start_chunk(1, 1, 0, 0, 0, 1, 2);
    end_chunk(4'b1011, "R5 no turnaround");

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      ntest++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule